// File: doc/BRIEF.md
# Disk Controller Bus Register Interface

This block sits between a microcoded processor's internal bus and the disk datapath. A 4-bit function code with a valid strobe selects one of six register operations per cycle. The operations load the data-out word, load the record address and mode field, load the command bits, clear the error state, advance to the next record, and load the microcode-visible status bits. The registered results drive the datapath directly: the transfer enable, the word-task wakeup gate, the clock-source select, the track address lines and a bit counter that waits for the first 1 bit.

Each sector holds three records. The address load gives each record a 2-bit mode. An advance strobe shifts the mode field so that the next record's number and mode come to the front. Error inputs from the datapath set sticky status latches, which only the clear strobe empties. One of the microcode-writable status bits is OR-accumulated, so that microcode cannot erase a condition that is already flagged.

Top module: `dsk_bus_regs`

## Requirements
- R1: After reset, dout_o=0, stat_o=0, rec_num_o=0, rec_rd_o=1, bit_cnt_o is all ones, xfer_en_o=1, clk_xtal_o=0 and track_o=0.
- R2: With fn_vld_i=1 and fn_i=15 (octal 17), the data-out register takes all 16 bits of bus_i on the clock edge, and dout_o shows them.
- R3: fn_i=14 loads the address field from bus_i[7:1]: rec mode 0 from bus_i[6:5], mode 1 from [4:3], mode 2 from [2:1], and adr_flag_o from bus_i[7]. It also copies dout_o[2] into head_o and sets rec_num_o to 0.
- R4: fn_i=13 loads the command from bus_i[14:10] as {transfer block, wake inhibit, crystal clock, free run, send track}. The outputs are xfer_en_o = !block, clk_xtal_o = crystal clock, and word_wake_o = word_req_i & !inhibit.
- R5: track_o is {dout_o[11:3], dout_o[0]} while send track is 1, and 0 while send track is 0.
- R6: With free run at 0, bit_cnt_o stays all ones on each bit_stb_i whose bit_val_i is 0, until a strobe with bit_val_i=1 moves it to 0. After that, and whenever free run is 1, every strobe increments it. A command load with free run 0 re-arms the wait and sets the counter to all ones.
- R7: fn_i=11 increments rec_num_o, wrapping from 3 to 0, and shifts the next record's mode to the front. The vacated slot fills with read (0).
- R8: The current mode decodes to exactly one of rec_rd_o (0), rec_chk_o (1) or rec_wr_o (2 or 3), and rec_mode_o shows the code.
- R9: fn_i=10 writes stat_o[3], stat_o[1] and stat_o[0] from the same bus_i bits. stat_o[2] becomes its old value ORed with bus_i[2].
- R10: Bit i of err_set_i sets stat_o[4+i], and the bit stays set until a clear.
- R11: fn_i=12 clears stat_o[2] and every error latch, and leaves stat_o[3], stat_o[1] and stat_o[0] unchanged. An error input that is active in the same cycle as the clear is still latched.
- R12: fn_i outside 10..15, or fn_vld_i=0, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_i | input | 16 | Processor bus, bus bit 0 = bus_i[15] |
| fn_i | input | 4 | Function code |
| fn_vld_i | input | 1 | Function code valid |
| err_set_i | input | 3 | Datapath error set pulses |
| bit_stb_i | input | 1 | Disk bit received strobe |
| bit_val_i | input | 1 | Value of the received bit |
| word_req_i | input | 1 | Raw word-task wakeup request |
| dout_o | output | 16 | Data-out register |
| track_o | output | 10 | Track address to drive |
| head_o | output | 1 | Head select |
| adr_flag_o | output | 1 | Spare address-field bit |
| rec_num_o | output | 2 | Current record number |
| rec_mode_o | output | 2 | Current record mode code |
| rec_rd_o | output | 1 | Current record is read |
| rec_chk_o | output | 1 | Current record is check |
| rec_wr_o | output | 1 | Current record is write |
| xfer_en_o | output | 1 | Data transfer enabled |
| word_wake_o | output | 1 | Gated word-task wakeup |
| clk_xtal_o | output | 1 | Force crystal bit clock |
| bit_cnt_o | output | 4 | Disk bit counter |
| stat_o | output | 16 | Status readback |

## Verification
The status tests apply different bus patterns: all ones, then all zeros, then a mixed value. These patterns separate the OR-accumulated status bit from the overwritten bits. A clear that coincides with an error pulse shows which one takes priority. In the record test, the address load gives each record a different mode, and four advances follow. This shows the shift order, the read fill of the vacated slot and the number wrap. The bit-counter test sends zeros, then a one, then a command load that changes free run, which covers the wait, the release and the re-arm. Unused codes and a function code held without its valid strobe check that nothing else writes the registers.

// File: rtl/dsk_regs_pkg.sv
package dsk_regs_pkg;
  localparam int BUS_W = 16;

  typedef enum logic [3:0] {
    FN_STAT_LD  = 4'o12,
    FN_REC_ADV  = 4'o13,
    FN_STAT_CLR = 4'o14,
    FN_CMD_LD   = 4'o15,
    FN_ADR_LD   = 4'o16,
    FN_DATA_LD  = 4'o17
  } fn_e;

  typedef enum logic [1:0] {
    MD_READ  = 2'd0,
    MD_CHECK = 2'd1,
    MD_WRITE = 2'd2,
    MD_WRALT = 2'd3
  } rec_mode_e;

  // order matches bus_i[14:10]
  typedef struct packed {
    logic xfer_blk;
    logic wake_inh;
    logic xtal;
    logic run;
    logic send;
  } cmd_t;

  typedef struct packed {
    logic stat_ld;
    logic rec_adv;
    logic stat_clr;
    logic cmd_ld;
    logic adr_ld;
    logic data_ld;
  } strb_t;
endpackage

// File: rtl/dsk_fn_dec.sv
module dsk_fn_dec
  import dsk_regs_pkg::*;
(
  input  logic [3:0] fn_i,
  input  logic       vld_i,
  output strb_t      strb_o
);
  always_comb begin
    strb_o = '0;
    if (vld_i) begin
      case (fn_i)
        FN_STAT_LD:  strb_o.stat_ld  = 1'b1;
        FN_REC_ADV:  strb_o.rec_adv  = 1'b1;
        FN_STAT_CLR: strb_o.stat_clr = 1'b1;
        FN_CMD_LD:   strb_o.cmd_ld   = 1'b1;
        FN_ADR_LD:   strb_o.adr_ld   = 1'b1;
        FN_DATA_LD:  strb_o.data_ld  = 1'b1;
        default:     strb_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dsk_rec_sr.sv
module dsk_rec_sr
  import dsk_regs_pkg::*;
#(
  parameter int REC_N  = 3,
  parameter int MODE_W = 2,
  parameter int RNUM_W = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ld_i,
  input  logic                      adv_i,
  input  logic [REC_N*MODE_W-1:0]   modes_i,
  output logic [RNUM_W-1:0]         num_o,
  output logic [MODE_W-1:0]         mode_o,
  output logic                      rd_o,
  output logic                      chk_o,
  output logic                      wr_o
);
  localparam int SR_W = REC_N * MODE_W;

  logic [SR_W-1:0]   sr_q;
  logic [RNUM_W-1:0] num_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      num_q <= '0;
    end else if (ld_i) begin
      sr_q  <= modes_i;
      num_q <= '0;
    end else if (adv_i) begin
      sr_q  <= {sr_q[SR_W-MODE_W-1:0], MODE_W'(MD_READ)};
      num_q <= num_q + 1'b1;
    end
  end

  assign num_o  = num_q;
  assign mode_o = sr_q[SR_W-1 -: MODE_W];

  always_comb begin
    rd_o  = 1'b0;
    chk_o = 1'b0;
    wr_o  = 1'b0;
    case (mode_o)
      MODE_W'(MD_READ):  rd_o  = 1'b1;
      MODE_W'(MD_CHECK): chk_o = 1'b1;
      default:           wr_o  = 1'b1;
    endcase
  end

  assert_mode_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({rd_o, chk_o, wr_o}))
    else $error("record mode decode not one-hot");

  assert_adv_num_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !ld_i) |=> num_q == $past(num_q) + 1'b1)
    else $error("record number did not advance");

  assert_adv_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !ld_i) |=> mode_o == $past(sr_q[SR_W-MODE_W-1 -: MODE_W]))
    else $error("next record mode not presented");

  assert_ld_num_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> num_q == '0)
    else $error("record number not reset by address load");
endmodule

// File: rtl/dsk_stat.sv
module dsk_stat #(
  parameter int ERR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             clr_i,
  input  logic [3:0]       fld_i,
  input  logic [ERR_W-1:0] err_i,
  output logic [15:0]      stat_o
);
  localparam int ERR_LSB = 4;

  logic [3:0]       sw_q;
  logic [ERR_W-1:0] err_q;

  // set wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= '0;
    else if (clr_i) err_q <= err_i;
    else            err_q <= err_q | err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q <= '0;
    end else if (ld_i) begin
      sw_q <= {fld_i[3], sw_q[2] | fld_i[2], fld_i[1:0]};
    end else if (clr_i) begin
      sw_q[2] <= 1'b0;
    end
  end

  always_comb begin
    stat_o = '0;
    stat_o[3:0] = sw_q;
    stat_o[ERR_LSB +: ERR_W] = err_q;
  end

  assert_or_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && sw_q[2]) |=> sw_q[2])
    else $error("accumulating status bit lost on load");

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (err_q & $past(err_q)) == $past(err_q))
    else $error("error latch dropped without clear");

  assert_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ld_i) |=> (!sw_q[2] && err_q == $past(err_i) && sw_q[3] == $past(sw_q[3])))
    else $error("clear status misbehaved");
endmodule

// File: rtl/dsk_bit_cnt.sv
module dsk_bit_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             arm_i,
  input  logic             stb_i,
  input  logic             val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      seen_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q  <= '1;
      seen_q <= 1'b0;
    end else if (stb_i) begin
      seen_q <= seen_q | val_i;
      if (run_i || seen_q || val_i) cnt_q <= cnt_q + 1'b1;
      else                          cnt_q <= '1;
    end
  end

  assign cnt_o = cnt_q;

  assert_hold_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !seen_q && !arm_i && !(stb_i && val_i)) |=> cnt_q == '1)
    else $error("bit counter left all-ones before first one bit");

  assert_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !arm_i && (run_i || seen_q)) |=> cnt_q == $past(cnt_q) + 1'b1)
    else $error("bit counter did not step");
endmodule

// File: rtl/dsk_bus_regs.sv
module dsk_bus_regs
  import dsk_regs_pkg::*;
#(
  parameter int ERR_W  = 3,
  parameter int REC_N  = 3,
  parameter int MODE_W = 2,
  parameter int RNUM_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       bus_i,
  input  logic [3:0]        fn_i,
  input  logic              fn_vld_i,
  input  logic [ERR_W-1:0]  err_set_i,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic              word_req_i,
  output logic [15:0]       dout_o,
  output logic [9:0]        track_o,
  output logic              head_o,
  output logic              adr_flag_o,
  output logic [RNUM_W-1:0] rec_num_o,
  output logic [MODE_W-1:0] rec_mode_o,
  output logic              rec_rd_o,
  output logic              rec_chk_o,
  output logic              rec_wr_o,
  output logic              xfer_en_o,
  output logic              word_wake_o,
  output logic              clk_xtal_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [15:0]       stat_o
);
  localparam int MODES_W = REC_N * MODE_W;
  localparam int ADR_LSB = 1;
  localparam int FLAG_B  = ADR_LSB + MODES_W;
  localparam int CMD_LSB = 10;
  localparam int HEAD_B  = 2;

  strb_t            strb;
  cmd_t             cmd_q;
  cmd_t             cmd_d;
  logic [BUS_W-1:0] dout_q;
  logic             head_q;
  logic             flag_q;

  dsk_fn_dec u_dec (
    .fn_i  (fn_i),
    .vld_i (fn_vld_i),
    .strb_o(strb)
  );

  assign cmd_d = cmd_t'(bus_i[CMD_LSB +: $bits(cmd_t)]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      cmd_q  <= '0;
      head_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (strb.data_ld) dout_q <= bus_i;
      if (strb.cmd_ld)  cmd_q  <= cmd_d;
      if (strb.adr_ld) begin
        head_q <= dout_q[HEAD_B];
        flag_q <= bus_i[FLAG_B];
      end
    end
  end

  dsk_rec_sr #(
    .REC_N (REC_N),
    .MODE_W(MODE_W),
    .RNUM_W(RNUM_W)
  ) u_rec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (strb.adr_ld),
    .adv_i  (strb.rec_adv),
    .modes_i(bus_i[ADR_LSB +: MODES_W]),
    .num_o  (rec_num_o),
    .mode_o (rec_mode_o),
    .rd_o   (rec_rd_o),
    .chk_o  (rec_chk_o),
    .wr_o   (rec_wr_o)
  );

  dsk_stat #(
    .ERR_W(ERR_W)
  ) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (strb.stat_ld),
    .clr_i (strb.stat_clr),
    .fld_i (bus_i[3:0]),
    .err_i (err_set_i),
    .stat_o(stat_o)
  );

  dsk_bit_cnt #(
    .CNT_W(CNT_W)
  ) u_bcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (cmd_q.run),
    .arm_i (strb.cmd_ld && !cmd_d.run),
    .stb_i (bit_stb_i),
    .val_i (bit_val_i),
    .cnt_o (bit_cnt_o)
  );

  assign dout_o      = dout_q;
  assign head_o      = head_q;
  assign adr_flag_o  = flag_q;
  assign xfer_en_o   = !cmd_q.xfer_blk;
  assign clk_xtal_o  = cmd_q.xtal;
  assign word_wake_o = word_req_i && !cmd_q.wake_inh;
  assign track_o     = cmd_q.send ? {dout_q[11:3], dout_q[0]} : 10'd0;

  assert_data_ld_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.data_ld |=> dout_q == $past(bus_i))
    else $error("data-out load mismatch");

  assert_head_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.adr_ld |=> head_q == $past(dout_q[HEAD_B]))
    else $error("head bit not taken from data-out");

  assert_ignore_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fn_vld_i |=> ($stable(dout_q) && $stable(cmd_q) && $stable(head_q) && $stable(flag_q)))
    else $error("register changed without a strobe");

  assert_track_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_q.send |-> track_o == 10'd0)
    else $error("track address driven while send off");
endmodule

// File: tb/tb_dsk_bus_regs.sv
`timescale 1ns/1ps
module tb_dsk_bus_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bus_i = '0;
  logic [3:0]  fn_i = '0;
  logic        fn_vld_i = 1'b0;
  logic [2:0]  err_set_i = '0;
  logic        bit_stb_i = 1'b0;
  logic        bit_val_i = 1'b0;
  logic        word_req_i = 1'b0;
  logic [15:0] dout_o;
  logic [9:0]  track_o;
  logic        head_o, adr_flag_o;
  logic [1:0]  rec_num_o, rec_mode_o;
  logic        rec_rd_o, rec_chk_o, rec_wr_o;
  logic        xfer_en_o, word_wake_o, clk_xtal_o;
  logic [3:0]  bit_cnt_o;
  logic [15:0] stat_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  dsk_bus_regs dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_i(bus_i), .fn_i(fn_i), .fn_vld_i(fn_vld_i),
    .err_set_i(err_set_i), .bit_stb_i(bit_stb_i), .bit_val_i(bit_val_i),
    .word_req_i(word_req_i), .dout_o(dout_o), .track_o(track_o), .head_o(head_o),
    .adr_flag_o(adr_flag_o), .rec_num_o(rec_num_o), .rec_mode_o(rec_mode_o),
    .rec_rd_o(rec_rd_o), .rec_chk_o(rec_chk_o), .rec_wr_o(rec_wr_o),
    .xfer_en_o(xfer_en_o), .word_wake_o(word_wake_o), .clk_xtal_o(clk_xtal_o),
    .bit_cnt_o(bit_cnt_o), .stat_o(stat_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic strobe(input logic [3:0] code, input logic [15:0] val, input logic vld = 1'b1);
    @(negedge clk_i);
    fn_i = code; bus_i = val; fn_vld_i = vld;
    @(negedge clk_i);
    fn_vld_i = 1'b0; fn_i = '0; bus_i = '0;
  endtask

  task automatic bit_in(input logic v);
    @(negedge clk_i);
    bit_stb_i = 1'b1; bit_val_i = v;
    @(negedge clk_i);
    bit_stb_i = 1'b0; bit_val_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "dout", 32'(dout_o), 0);
    check("R1", "stat", 32'(stat_o), 0);
    check("R1", "rec_num", 32'(rec_num_o), 0);
    check("R1", "rd", 32'(rec_rd_o), 1);
    check("R1", "bit_cnt", 32'(bit_cnt_o), 32'hF);
    check("R1", "xfer_en", 32'(xfer_en_o), 1);
    check("R1", "xtal", 32'(clk_xtal_o), 0);
    check("R1", "track", 32'(track_o), 0);
  endtask

  task automatic t_data();
    strobe(4'o17, 16'hA5C3);
    check("R2", "dout", 32'(dout_o), 32'hA5C3);
    strobe(4'o17, 16'h5A3C);
    check("R2", "dout 2nd", 32'(dout_o), 32'h5A3C);
  endtask

  task automatic t_cmd_track();
    logic [15:0] d = 16'hA5C3;
    strobe(4'o17, d);
    strobe(4'o15, 16'h0400);
    check("R5", "track send", 32'(track_o), 32'({d[11:3], d[0]}));
    check("R4", "xfer_en", 32'(xfer_en_o), 1);
    strobe(4'o15, 16'h0000);
    check("R5", "track off", 32'(track_o), 0);
    strobe(4'o15, 16'h4000);
    check("R4", "xfer blocked", 32'(xfer_en_o), 0);
    strobe(4'o15, 16'h1000);
    check("R4", "xtal", 32'(clk_xtal_o), 1);
    check("R4", "xfer reopened", 32'(xfer_en_o), 1);
    word_req_i = 1'b1;
    #1 check("R4", "wake pass", 32'(word_wake_o), 1);
    strobe(4'o15, 16'h2000);
    check("R4", "wake inhibit", 32'(word_wake_o), 0);
    word_req_i = 1'b0;
    strobe(4'o15, 16'h0000);
  endtask

  task automatic t_record();
    strobe(4'o17, 16'h0004);
    // flag=1, rec0=write(2), rec1=check(1), rec2=read(0)
    strobe(4'o16, 16'h00C8);
    check("R3", "head", 32'(head_o), 1);
    check("R3", "flag", 32'(adr_flag_o), 1);
    check("R3", "num", 32'(rec_num_o), 0);
    check("R8", "mode wr", 32'({rec_mode_o, rec_rd_o, rec_chk_o, rec_wr_o}), 32'b10_001);
    strobe(4'o13, 16'h0000);
    check("R7", "num 1", 32'(rec_num_o), 1);
    check("R8", "mode chk", 32'({rec_mode_o, rec_rd_o, rec_chk_o, rec_wr_o}), 32'b01_010);
    strobe(4'o13, 16'h0000);
    check("R7", "num 2", 32'(rec_num_o), 2);
    check("R8", "mode rd", 32'({rec_mode_o, rec_rd_o, rec_chk_o, rec_wr_o}), 32'b00_100);
    strobe(4'o13, 16'h0000);
    check("R7", "fill read", 32'({rec_num_o, rec_rd_o}), 32'b11_1);
    strobe(4'o13, 16'h0000);
    check("R7", "wrap", 32'(rec_num_o), 0);
    // rec0 mode 3 also decodes as write
    strobe(4'o17, 16'h0000);
    strobe(4'o16, 16'h0060);
    check("R8", "mode 3 wr", 32'({rec_mode_o, rec_wr_o, head_o, adr_flag_o}), 32'b11_1_0_0);
  endtask

  task automatic t_bitcnt();
    strobe(4'o15, 16'h0000);
    bit_in(1'b0); bit_in(1'b0);
    check("R6", "hold ones", 32'(bit_cnt_o), 32'hF);
    bit_in(1'b1);
    check("R6", "first one", 32'(bit_cnt_o), 0);
    bit_in(1'b0);
    check("R6", "counting", 32'(bit_cnt_o), 1);
    strobe(4'o15, 16'h0800);
    bit_in(1'b0);
    check("R6", "free run", 32'(bit_cnt_o), 2);
    strobe(4'o15, 16'h0000);
    check("R6", "re-arm", 32'(bit_cnt_o), 32'hF);
    bit_in(1'b0);
    check("R6", "re-armed hold", 32'(bit_cnt_o), 32'hF);
  endtask

  task automatic t_status();
    strobe(4'o12, 16'h000F);
    check("R9", "load F", 32'(stat_o), 32'hF);
    strobe(4'o12, 16'h0000);
    check("R9", "or bit kept", 32'(stat_o), 32'h4);
    strobe(4'o14, 16'h0000);
    check("R11", "clear", 32'(stat_o), 0);
    strobe(4'o12, 16'h000B);
    check("R9", "load B", 32'(stat_o), 32'hB);
    @(negedge clk_i); err_set_i = 3'b010;
    @(negedge clk_i); err_set_i = 3'b000;
    repeat (3) @(negedge clk_i);
    check("R10", "sticky", 32'(stat_o), 32'h2B);
    @(negedge clk_i);
    fn_i = 4'o14; fn_vld_i = 1'b1; err_set_i = 3'b001;
    @(negedge clk_i);
    fn_vld_i = 1'b0; fn_i = '0; err_set_i = '0;
    check("R11", "set beats clear", 32'(stat_o), 32'h1B);
    strobe(4'o14, 16'h0000);
    check("R11", "clear keeps sw bits", 32'(stat_o), 32'hB);
  endtask

  task automatic t_ignore();
    strobe(4'o17, 16'h1234);
    strobe(4'o11, 16'hFFFF);
    strobe(4'o07, 16'hFFFF);
    strobe(4'o17, 16'hFFFF, 1'b0);
    strobe(4'o12, 16'h000F, 1'b0);
    check("R12", "dout", 32'(dout_o), 32'h1234);
    check("R12", "stat", 32'(stat_o), 32'hB);
    check("R12", "cmd", 32'({xfer_en_o, clk_xtal_o, track_o}), 32'h800);
    check("R12", "rec", 32'({rec_num_o, rec_mode_o}), 32'b00_11);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_data();
    t_cmd_track();
    t_record();
    t_bitcnt();
    t_status();
    t_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule